// File: doc/BRIEF.md
# Redundant-Binary Row Accumulator and Converter

This combinational block takes a power-of-two number of signed-digit rows and produces their sum as an ordinary two's complement word. Each row has 2N digits, and each digit is a pair of bits: a positive flag and a negative flag. The digit's value is the positive flag minus the negative flag. Typical inputs are the partial-product rows of a multiplier that works in signed-digit form. The rows can, however, be any legal digit vectors.

The rows are paired and summed in a balanced tree of signed-digit adders. Each level halves the number of rows. No adder in the tree passes a carry further than two digit positions, so the delay of one level does not depend on the width. One final stage then subtracts the negative-flag vector from the positive-flag vector. It uses block carry-select sums whose block carry-ins come from a parallel-prefix network. The result is taken modulo 2^(2N).

Top module: `rb_accum`

## Requirements
- R1: Digit i of row r sits at bit r*2N+i of both input vectors. A digit with the positive flag set and the negative flag clear weighs +2^i. The opposite pair weighs -2^i. Both flags clear, or both set, weighs zero.
- R2: `prod_o` equals the sum of all row values, taken modulo 2^(2N) in two's complement, for any legal inputs.
- R3: ROWS is a power of two of at least 2. The tree has log2(ROWS) levels and each level halves the row count. The block is correct for ROWS=4 with N=8 and for ROWS=2 with N=16.
- R4: Transfers out of the top digit position are discarded. With every positive flag set and every negative flag clear, the output is 2^(2N) - ROWS.
- R5: If every digit of every row weighs zero, including digits with both flags set, `prod_o` is zero.
- R6: If all negative flags are clear, `prod_o` is the binary sum of the positive-flag vectors modulo 2^(2N).
- R7: If all positive flags are clear, `prod_o` is the two's complement negation of the binary sum of the negative-flag vectors.
- R8: If only row 0 holds nonzero flags, `prod_o` equals row 0's positive vector minus its negative vector modulo 2^(2N).
- R9: A borrow carries through the whole width. A value of -1 gives all ones. A value of 2^(2N-1)-1, written as a top digit of +1 and a bottom digit of -1, gives 0 followed by all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rows_p_i | input | ROWS*2N | Positive flags of all rows, row r in bits [r*2N +: 2N] |
| rows_m_i | input | ROWS*2N | Negative flags of all rows, same layout |
| prod_o | output | 2N | Two's complement sum modulo 2^(2N) |

## Verification
The bench goes after digits whose lower neighbour is negative. If the transfer rule ignored that neighbour, a final digit would go out of range and the output would be wrong by a power of two. It builds full-width borrow chains and near-cancelling rows that stress the block carry-ins of the converter. A wrong prefix combine, or a swapped carry select, would corrupt whole upper blocks. All-ones rows force transfers out of the top digit, and digits with both flags set must read as zero rather than as a stray unit. A pure random mix runs on both tree depths to catch wiring errors between levels.

// File: rtl/rb_accum_pkg.sv
package rb_accum_pkg;

    // Value of a two-flag digit as an integer.
    function automatic int dig_val(input logic p, input logic m);
        return (p ? 1 : 0) - (m ? 1 : 0);
    endfunction

    // Transfer digit {p,m} sent upward from a position.
    // low_neg: the next lower position holds at least one -1 operand.
    function automatic logic [1:0] rb_xfer(input logic xp, input logic xm,
                                           input logic yp, input logic ym,
                                           input logic low_neg);
        int s;
        s = dig_val(xp, xm) + dig_val(yp, ym);
        case (s)
            2:       return 2'b10;
            -2:      return 2'b01;
            1:       return low_neg ? 2'b00 : 2'b10;
            -1:      return low_neg ? 2'b01 : 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    // Interim digit {p,m} kept at a position.
    function automatic logic [1:0] rb_interim(input logic xp, input logic xm,
                                              input logic yp, input logic ym,
                                              input logic low_neg);
        int s;
        s = dig_val(xp, xm) + dig_val(yp, ym);
        if (s == 1 || s == -1) begin
            return low_neg ? 2'b10 : 2'b01;
        end
        return 2'b00;
    endfunction

    // First node index of tree level lvl in a flat node array.
    function automatic int lvl_base(input int rows, input int lvl);
        int b;
        b = 0;
        for (int k = 0; k < lvl; k++) begin
            b = b + (rows >> k);
        end
        return b;
    endfunction

endpackage

// File: rtl/rb_row_add.sv
module rb_row_add
    import rb_accum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] ap,
    input  logic [W-1:0] am,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] bm,
    output logic [W-1:0] sp,
    output logic [W-1:0] sm
);

    logic [W-1:0] wp, wm, lneg;
    logic [W-2:0] tp, tm;

    for (genvar i = 0; i < W; i++) begin : g_dig
        if (i == 0) begin : g_lsb
            assign lneg[i] = 1'b0;
        end else begin : g_mid
            assign lneg[i] = (am[i-1] & ~ap[i-1]) | (bm[i-1] & ~bp[i-1]);
        end

        assign {wp[i], wm[i]} = rb_interim(ap[i], am[i], bp[i], bm[i], lneg[i]);

        // Top position emits no transfer: it is dropped modulo 2^W.
        if (i < W - 1) begin : g_xf
            assign {tp[i], tm[i]} = rb_xfer(ap[i], am[i], bp[i], bm[i], lneg[i]);
        end

        if (i == 0) begin : g_s0
            assign sp[i] = wp[i];
            assign sm[i] = wm[i];
        end else begin : g_sn
            assign sp[i] = (wp[i] & ~tm[i-1]) | (tp[i-1] & ~wm[i]);
            assign sm[i] = (wm[i] & ~tp[i-1]) | (tm[i-1] & ~wp[i]);
        end
    end

endmodule

// File: rtl/rb_conv.sv
module rb_conv #(
    parameter int W   = 16,
    parameter int BLK = 4
) (
    input  logic [W-1:0] pv,
    input  logic [W-1:0] mv,
    output logic [W-1:0] bin
);

    localparam int NB  = W / BLK;
    localparam int NP  = NB - 1;
    localparam int STG = (NP > 1) ? $clog2(NP) : 1;

    function automatic logic [BLK:0] blk_add(input logic [BLK-1:0] a,
                                             input logic [BLK-1:0] b,
                                             input logic ci);
        logic [BLK:0] r;
        logic c;
        c = ci;
        for (int i = 0; i < BLK; i++) begin
            r[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        r[BLK] = c;
        return r;
    endfunction

    function automatic logic [BLK-1:0] blk_sum(input logic [BLK-1:0] a,
                                               input logic [BLK-1:0] b,
                                               input logic ci);
        logic [BLK:0] r;
        r = blk_add(a, b, ci);
        return r[BLK-1:0];
    endfunction

    logic [W-1:0]  mb, s0, s1;
    logic [NP-1:0] bg, bp, gg, pp, gn, pn;

    assign mb = ~mv;

    // Block sums for both carry-ins; block carry-outs for the prefix.
    for (genvar k = 0; k < NB; k++) begin : g_blk
        if (k < NP) begin : g_full
            logic [BLK:0] r0, r1;
            assign r0 = blk_add(pv[k*BLK +: BLK], mb[k*BLK +: BLK], 1'b0);
            assign r1 = blk_add(pv[k*BLK +: BLK], mb[k*BLK +: BLK], 1'b1);
            assign s0[k*BLK +: BLK] = r0[BLK-1:0];
            assign s1[k*BLK +: BLK] = r1[BLK-1:0];
            assign bg[k] = r0[BLK];
            assign bp[k] = r1[BLK];
        end else begin : g_top
            assign s0[k*BLK +: BLK] = blk_sum(pv[k*BLK +: BLK], mb[k*BLK +: BLK], 1'b0);
            assign s1[k*BLK +: BLK] = blk_sum(pv[k*BLK +: BLK], mb[k*BLK +: BLK], 1'b1);
        end
    end

    // Parallel prefix over block carries; pp[k] = carry out of blocks 0..k
    // when the word carry-in is 1 (the +1 of the subtraction).
    always_comb begin
        gg = bg;
        pp = bp;
        gn = bg;
        pn = bp;
        for (int s = 0; s < STG; s++) begin
            gn = gg;
            pn = pp;
            for (int k = 0; k < NP; k++) begin
                int j;
                j = (k >= (1 << s)) ? (k - (1 << s)) : 0;
                if (k >= (1 << s)) begin
                    gn[k] = gg[k] | (pp[k] & gg[j]);
                    pn[k] = gg[k] | (pp[k] & pp[j]);
                end
            end
            gg = gn;
            pp = pn;
        end
    end

    for (genvar k = 0; k < NB; k++) begin : g_sel
        if (k == 0) begin : g_b0
            assign bin[k*BLK +: BLK] = s1[k*BLK +: BLK];
        end else begin : g_bn
            assign bin[k*BLK +: BLK] = pp[k-1] ? s1[k*BLK +: BLK] : s0[k*BLK +: BLK];
        end
    end

endmodule

// File: rtl/rb_accum.sv
module rb_accum
    import rb_accum_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int N    = 8,
    parameter int BLK  = 4,
    localparam int W   = 2 * N
) (
    input  logic [ROWS*W-1:0] rows_p_i,
    input  logic [ROWS*W-1:0] rows_m_i,
    output logic [W-1:0]      prod_o
);

    localparam int LVLS  = $clog2(ROWS);
    localparam int NODES = 2 * ROWS - 1;

    logic [W-1:0] np [NODES];
    logic [W-1:0] nm [NODES];

    for (genvar r = 0; r < ROWS; r++) begin : g_leaf
        assign np[r] = rows_p_i[r*W +: W];
        assign nm[r] = rows_m_i[r*W +: W];
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int SRC = lvl_base(ROWS, l);
        localparam int DST = lvl_base(ROWS, l + 1);
        for (genvar j = 0; j < (ROWS >> (l + 1)); j++) begin : g_pair
            rb_row_add #(.W(W)) u_add (
                .ap (np[SRC + 2*j]),
                .am (nm[SRC + 2*j]),
                .bp (np[SRC + 2*j + 1]),
                .bm (nm[SRC + 2*j + 1]),
                .sp (np[DST + j]),
                .sm (nm[DST + j])
            );
        end
    end

    rb_conv #(.W(W), .BLK(BLK)) u_conv (
        .pv  (np[NODES-1]),
        .mv  (nm[NODES-1]),
        .bin (prod_o)
    );

endmodule

// File: rtl/rb_accum_chk.sv
module rb_accum_chk #(
    parameter int ROWS = 4,
    parameter int N    = 8,
    localparam int W   = 2 * N
) (
    input logic [ROWS*W-1:0] rows_p_i,
    input logic [ROWS*W-1:0] rows_m_i,
    input logic [W-1:0]      prod_o
);

    logic [W-1:0] psum, msum;

    always_comb begin
        psum = '0;
        msum = '0;
        for (int r = 0; r < ROWS; r++) begin
            psum = psum + rows_p_i[r*W +: W];
            msum = msum + rows_m_i[r*W +: W];
        end
    end

    always_comb begin
        // R5: zero-valued digits everywhere give zero
        if (rows_p_i == rows_m_i) begin
            a_r5_zero_value: assert (prod_o == '0)
                else $error("R5 zero-valued rows gave %h", prod_o);
        end
        // R6: plus flags only
        if (rows_m_i == '0) begin
            a_r6_plus_only: assert (prod_o == psum)
                else $error("R6 plus-only mismatch %h vs %h", prod_o, psum);
        end
        // R7: minus flags only
        if (rows_p_i == '0) begin
            a_r7_minus_only: assert (prod_o == W'(0 - msum))
                else $error("R7 minus-only mismatch %h", prod_o);
        end
        // R8: only row 0 active
        if (rows_p_i[ROWS*W-1:W] == '0 && rows_m_i[ROWS*W-1:W] == '0) begin
            a_r8_single_row: assert (prod_o == W'(rows_p_i[W-1:0] - rows_m_i[W-1:0]))
                else $error("R8 single-row mismatch %h", prod_o);
        end
    end

endmodule

bind rb_accum rb_accum_chk #(.ROWS(ROWS), .N(N)) u_chk (
    .rows_p_i (rows_p_i),
    .rows_m_i (rows_m_i),
    .prod_o   (prod_o)
);

// File: tb/rb_accum_bench.sv
module rb_accum_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [63:0] p4 = '0, m4 = '0, p2 = '0, m2 = '0;
    logic [15:0] y4;
    logic [31:0] y2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // ROWS=4, N=8
    rb_accum #(.ROWS(4), .N(8)) u_rb_accum (
        .rows_p_i (p4), .rows_m_i (m4), .prod_o (y4));
    // ROWS=2, N=16
    rb_accum #(.ROWS(2), .N(16)) u_rb_accum_r2 (
        .rows_p_i (p2), .rows_m_i (m2), .prod_o (y2));

    function automatic longint expv(input logic [63:0] p, input logic [63:0] m,
                                    input int rows, input int w);
        longint s;
        s = 0;
        for (int r = 0; r < rows; r++) begin
            for (int i = 0; i < w; i++) begin
                if (p[r*w+i]) s = s + (longint'(1) << i);
                if (m[r*w+i]) s = s - (longint'(1) << i);
            end
        end
        return s & ((longint'(1) << w) - 1);
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run4(input logic [63:0] p, input logic [63:0] m, input string tag);
        @(posedge clk);
        p4 <= p;
        m4 <= m;
        @(negedge clk);
        chk(tag, longint'(y4), expv(p, m, 4, 16));
    endtask

    task automatic run2(input logic [63:0] p, input logic [63:0] m, input string tag);
        @(posedge clk);
        p2 <= p;
        m2 <= m;
        @(negedge clk);
        chk(tag, longint'(y2), expv(p, m, 2, 32));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired got hang expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] rp, rm;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state with all-zero inputs
        chk("R5 reset zero r4", longint'(y4), 0);
        chk("R5 reset zero r2", longint'(y2), 0);
        rst = 1'b0;

        // R1: digit weight and sign at bit 3 of row 1
        run4(64'h0000_0000_0008_0000, 64'h0, "R1 plus digit weight");
        chk("R1 plus digit value", longint'(y4), 64'h8);
        run4(64'h0, 64'h0000_0000_0008_0000, "R1 minus digit weight");
        chk("R1 minus digit value", longint'(y4), 64'hFFF8);
        // R5: both flags set reads as zero
        run4('1, '1, "R5 both flags set r4");
        run2('1, '1, "R5 both flags set r2");
        // R4: wrap of top transfers
        run4('1, '0, "R4 all plus wrap r4");
        chk("R4 value 2^16-4", longint'(y4), 64'hFFFC);
        run2('1, '0, "R4 all plus wrap r2");
        chk("R4 value 2^32-2", longint'(y2), 64'hFFFF_FFFE);
        // R9: full-width borrow chains
        run4(64'h0, 64'h1, "R9 minus one r4");
        chk("R9 all ones r4", longint'(y4), 64'hFFFF);
        run4(64'h8000, 64'h1, "R9 top plus bottom minus r4");
        chk("R9 7fff r4", longint'(y4), 64'h7FFF);
        run2(64'h8000_0000, 64'h1, "R9 top plus bottom minus r2");
        chk("R9 7fffffff r2", longint'(y2), 64'h7FFF_FFFF);
        // R9: cancelling rows leaving one unit at the top of the chain
        run4(64'h0001_0000_0000_FFFF, 64'h0000_FFFF_FFFF_0000, "R9 near cancel r4");

        for (int n = 0; n < 40; n++) begin
            rp = {$urandom, $urandom};
            rm = {$urandom, $urandom};
            run4(rp, '0, "R6 plus only r4");
            run2(rp, '0, "R6 plus only r2");
            run4('0, rm, "R7 minus only r4");
            run2('0, rm, "R7 minus only r2");
            run4({48'h0, rp[15:0]}, {48'h0, rm[15:0]}, "R8 single row r4");
            run2({32'h0, rp[31:0]}, {32'h0, rm[31:0]}, "R8 single row r2");
        end

        // R2 / R3: random mixes on both tree depths
        for (int n = 0; n < 300; n++) begin
            rp = {$urandom, $urandom};
            rm = {$urandom, $urandom};
            run4(rp, rm, "R2 R3 random r4");
            run2(rp, rm, "R2 R3 random r2");
        end
        // R2: negatives under positives (lower neighbour negative)
        for (int n = 0; n < 100; n++) begin
            rp = {$urandom, $urandom} & 64'hAAAA_AAAA_AAAA_AAAA;
            rm = {$urandom, $urandom} & 64'h5555_5555_5555_5555;
            run4(rp, rm, "R2 interleaved r4");
            run2(rm, rp, "R2 interleaved r2");
        end
        finish_run();
    end

endmodule